// File: doc/BRIEF.md
# Converter Channel Interrupt Vector Hub

This block sits between up to seven converter channels and a CPU. Each channel hands over a finished 32-bit filter result with a one-cycle strobe. The hub stores the result and sets a result-ready flag. If a result lands before the previous one was read, it also sets an overflow flag. A per-channel settling delay hides the first few results after a conversion starts, so an unsettled filter output raises nothing.

The CPU talks to the hub through a plain register port and sees four kinds of registers:
- a global register holding the overflow enable and the global interrupt enable;
- a read-only vector register that names the most urgent enabled pending source;
- per-channel control and input registers;
- per-channel 16-bit result windows onto the 32-bit result.

The hub drives one interrupt line. Software reads the vector to pick a handler, then clears the source by reading the result or by writing the flag. Any other pending source keeps the line high.

The result input is a valid-only stream. The hub never pushes back and accepts a result in every cycle that `res_valid` is high. A result that replaces an unread one is not stalled: the overflow flag records it.

Register map (5-bit address):
- 0x00 is the global register, with bit0 the overflow enable and bit1 the global interrupt enable.
- 0x01 is the vector register.
- 0x08+c is the control register of channel c.
- 0x10+c is the input register of channel c.
- 0x18+c is the result window of channel c.

Top module: `cvt_irq_hub`

## Requirements
- R1: After reset every register reads zero, the vector reads 0x00 and `irq` is low.
- R2: The vector reads 0x02 when overflow is pending, which has the highest priority. Otherwise it reads 0x04 + 2*c for the lowest-numbered channel c whose result-ready flag is pending, and 0x00 when nothing is pending.
- R3: A channel whose enable (control bit1) is 0 takes no part in the vector. Overflow flags take no part when the global overflow enable (global bit0) is 0.
- R4: Reading or writing the vector register (0x01) leaves every result-ready and overflow flag unchanged.
- R5: Control bit2 is the result-ready flag. An accepted result sets it. A read of the channel's result window clears it, and so does a control write with bit2 = 0; a control write with bit2 = 1 leaves it as it is.
- R6: Control bit3 is the overflow flag. It sets when a result is accepted while the result-ready flag is still set and not being read in that cycle. Only a control write with bit3 = 0 clears it; reading the result does not.
- R7: Input register bits 1:0 select the first result that raises a flag after a start: 00 the fourth, 01 the third, 10 the second, 11 the first. The results before it set neither flag, even when the ready flag is already set.
- R8: The delay restarts whenever the input register is written or a control write has bit0 (start) set. Bit0 always reads back as 0. Input register bits 4:2 (gain) and 7:5 (input select) read back as written.
- R9: With control bit4 = 0 the window shows result bits 15:0, and with bit4 = 1 it shows bits 31:16. When control bit5 is 1, bit4 flips after every read of the window.
- R10: `irq` is high exactly when global bit1 is set and at least one enabled source is pending. It stays high while any such source remains, so the next source follows when the first is cleared.
- R11: When a window read and a new result for the same channel fall in one cycle, the read returns the previous result. The ready flag stays set for the new result and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is valid in the same cycle |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data |
| res_valid | input | 1 | Result strobe; always accepted |
| res_chan | input | 3 | Channel of the result |
| res_data | input | 32 | Filter result |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- at most one register access happens per cycle;
- `res_chan` is always below the channel count when `res_valid` is high;
- a start or input-register write never lands in the same cycle as a result for that channel.

The bench drives every access and every result as its own single-cycle task with an idle edge between tasks. It only makes the read and the new result coincide in the one task written for that case (R11). Flags change only in ways the assertions can attribute to a single cause.

// File: rtl/cvt_irq_pkg.sv
package cvt_irq_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned CH_W   = 3;

  // address pages: addr[4:3] picks the page, addr[2:0] the channel
  localparam logic [1:0] PG_GLB = 2'b00;
  localparam logic [1:0] PG_CTL = 2'b01;
  localparam logic [1:0] PG_INP = 2'b10;
  localparam logic [1:0] PG_RES = 2'b11;
  localparam logic [CH_W-1:0] SEL_GLB = 3'd0;
  localparam logic [CH_W-1:0] SEL_VEC = 3'd1;

  // control register bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_IE    = 1;
  localparam int unsigned B_RDY   = 2;
  localparam int unsigned B_OVF   = 3;
  localparam int unsigned B_HI    = 4;
  localparam int unsigned B_TOG   = 5;
  localparam int unsigned CTL_W   = 6;

  localparam logic [VEC_W-1:0] VEC_NONE = 8'h00;
  localparam logic [VEC_W-1:0] VEC_OVF  = 8'h02;
endpackage

// File: rtl/cvt_chan_state.sv
module cvt_chan_state
  import cvt_irq_pkg::*;
#(
  parameter int unsigned RES_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wd,
  input  logic                 inp_we,
  input  logic [7:0]           inp_wd,
  input  logic                 res_rd,
  input  logic                 smp,
  input  logic [RES_W-1:0]     smp_data,
  output logic                 rdy,
  output logic                 ovf,
  output logic                 ie,
  output logic [CTL_W-1:0]     ctl_q,
  output logic [7:0]           inp_q,
  output logic [RES_W/2-1:0]   win
);
  localparam int unsigned HALF = RES_W / 2;

  logic             ie_q, rdy_q, ovf_q, hi_q, tog_q;
  logic [1:0]       dly_q, skip_q;
  logic [2:0]       gain_q, isel_q;
  logic [RES_W-1:0] data_q;
  logic             restart;

  assign restart = (ctl_we && ctl_wd[B_START]) || inp_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= 1'b0; rdy_q <= 1'b0; ovf_q <= 1'b0; hi_q <= 1'b0; tog_q <= 1'b0;
      dly_q <= '0; skip_q <= '0; gain_q <= '0; isel_q <= '0; data_q <= '0;
    end else begin
      if (ctl_we) begin
        ie_q  <= ctl_wd[B_IE];
        hi_q  <= ctl_wd[B_HI];
        tog_q <= ctl_wd[B_TOG];
        if (!ctl_wd[B_RDY]) rdy_q <= 1'b0;
        if (!ctl_wd[B_OVF]) ovf_q <= 1'b0;
      end
      if (inp_we) begin
        dly_q  <= inp_wd[1:0];
        gain_q <= inp_wd[4:2];
        isel_q <= inp_wd[7:5];
      end
      if (res_rd) begin
        rdy_q <= 1'b0;
        if (tog_q) hi_q <= ~hi_q;
      end
      // remaining suppressed results = 3 - delay code
      if (restart) skip_q <= inp_we ? ~inp_wd[1:0] : ~dly_q;
      if (smp) begin
        data_q <= smp_data;
        if (!restart) begin
          if (skip_q != 2'd0) begin
            skip_q <= skip_q - 2'd1;
          end else begin
            rdy_q <= 1'b1;
            if (rdy_q && !res_rd) ovf_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rdy   = rdy_q;
  assign ovf   = ovf_q;
  assign ie    = ie_q;
  assign ctl_q = {tog_q, hi_q, ovf_q, rdy_q, ie_q, 1'b0};
  assign inp_q = {isel_q, gain_q, dly_q};
  assign win   = hi_q ? data_q[RES_W-1:HALF] : data_q[HALF-1:0];

  // R5: an accepted, unsuppressed result leaves the ready flag set
  p_ready_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && !restart && skip_q == 2'd0) |=> rdy_q);
  // R5: a window read with no new result clears the flag
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !smp) |=> !rdy_q);
  // R6: overflow falls only after a control write
  p_ovf_sw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_q) |-> $past(ctl_we));
  // R7: a suppressed result touches neither flag
  p_delay_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && skip_q != 2'd0 && !ctl_we && !inp_we && !res_rd)
      |=> ($stable(rdy_q) && $stable(ovf_q)));
  // R11: read and new result together keep the flag set
  p_read_and_new_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && smp && !restart && skip_q == 2'd0) |=> (rdy_q && $stable(ovf_q)));
endmodule

// File: rtl/cvt_vec_prio.sv
module cvt_vec_prio
  import cvt_irq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic             ovf_pend,
  input  logic [NCH-1:0]   ch_pend,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    vec = VEC_NONE;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ch_pend[i]) vec = VEC_W'(4 + 2 * i);
    end
    if (ovf_pend) vec = VEC_OVF;
  end
endmodule

// File: rtl/cvt_irq_hub.sv
module cvt_irq_hub
  import cvt_irq_pkg::*;
#(
  parameter int unsigned NCH   = 7,
  parameter int unsigned RES_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [RES_W/2-1:0]   reg_rdata,
  input  logic                 res_valid,
  input  logic [CH_W-1:0]      res_chan,
  input  logic [RES_W-1:0]     res_data,
  output logic                 irq
);
  localparam int unsigned DW = RES_W / 2;

  logic [1:0]      page;
  logic [CH_W-1:0] sel;
  logic            ovf_en_q, gie_q;
  logic [NCH-1:0]  rdy_v, ovf_v, ie_v, ctl_we, inp_we, res_rd, smp;
  logic [CTL_W-1:0] ctl_q [NCH];
  logic [7:0]       inp_q [NCH];
  logic [DW-1:0]    win   [NCH];
  logic            ovf_pend;
  logic [NCH-1:0]  ch_pend;
  logic [VEC_W-1:0] vec;

  assign page = reg_addr[ADDR_W-1:CH_W];
  assign sel  = reg_addr[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_en_q <= 1'b0;
      gie_q    <= 1'b0;
    end else if (reg_wr && page == PG_GLB && sel == SEL_GLB) begin
      ovf_en_q <= reg_wdata[0];
      gie_q    <= reg_wdata[1];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ctl_we[c] = reg_wr && page == PG_CTL && sel == CH_W'(c);
    assign inp_we[c] = reg_wr && page == PG_INP && sel == CH_W'(c);
    assign res_rd[c] = reg_rd && page == PG_RES && sel == CH_W'(c);
    assign smp[c]    = res_valid && res_chan == CH_W'(c);

    cvt_chan_state #(.RES_W(RES_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we[c]), .ctl_wd(reg_wdata[CTL_W-1:0]),
      .inp_we(inp_we[c]), .inp_wd(reg_wdata),
      .res_rd(res_rd[c]), .smp(smp[c]), .smp_data(res_data),
      .rdy(rdy_v[c]), .ovf(ovf_v[c]), .ie(ie_v[c]),
      .ctl_q(ctl_q[c]), .inp_q(inp_q[c]), .win(win[c])
    );
  end

  assign ovf_pend = ovf_en_q && (|ovf_v);
  assign ch_pend  = rdy_v & ie_v;

  cvt_vec_prio #(.NCH(NCH)) u_prio (
    .ovf_pend(ovf_pend), .ch_pend(ch_pend), .vec(vec)
  );

  assign irq = gie_q && (ovf_pend || (|ch_pend));

  always_comb begin
    reg_rdata = '0;
    unique case (page)
      PG_GLB: begin
        if (sel == SEL_GLB)      reg_rdata = DW'({gie_q, ovf_en_q});
        else if (sel == SEL_VEC) reg_rdata = DW'(vec);
      end
      PG_CTL: for (int c = 0; c < NCH; c++) if (sel == CH_W'(c)) reg_rdata = DW'(ctl_q[c]);
      PG_INP: for (int c = 0; c < NCH; c++) if (sel == CH_W'(c)) reg_rdata = DW'(inp_q[c]);
      default: for (int c = 0; c < NCH; c++) if (sel == CH_W'(c)) reg_rdata = win[c];
    endcase
  end

  // R4: a vector access alone changes no flag
  p_vec_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && page == PG_GLB && sel == SEL_VEC && !res_valid)
      |=> ($stable(rdy_v) && $stable(ovf_v)));
  // R10: a nonzero vector with the global enable raises the line
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && vec != VEC_NONE) |-> irq);
  // R2: overflow always wins the vector
  p_ovf_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_en_q && (|ovf_v)) |-> (vec == VEC_OVF));
endmodule

// File: tb/sim_cvt_irq_hub.sv
module sim_cvt_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        res_valid = 1'b0;
  logic [2:0]  res_chan = '0;
  logic [31:0] res_data = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cvt_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data), .irq(irq)
  );

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (reg_rd) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL read with no expectation: got %h", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [2:0] c, input logic [31:0] d);
    @(posedge clk); #1;
    res_chan = c; res_data = d; res_valid = 1'b1;
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic rd_push(input logic [2:0] c, input logic [15:0] e, input logic [31:0] d,
                         input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = 5'h18 + 5'(c); reg_rd = 1'b1;
    res_chan = c; res_data = d; res_valid = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0; res_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, 16'h0000, "R1 global");
    rd(5'h01, 16'h0000, "R1 vector");
    rd(5'h08, 16'h0000, "R1 ctl0");
    rd(5'h13, 16'h0000, "R1 inp3");
    chk_irq(1'b0, "R1 irq");

    wr(5'h00, 8'h03);
    for (int c = 0; c < 7; c++) wr(5'h08 + 5'(c), 8'h02);

    push(3'd3, 32'h1234_5678);
    rd(5'h01, 16'h000A, "R2 vector ch3");
    chk_irq(1'b1, "R10 irq ch3");
    rd(5'h0B, 16'h0006, "R5 ctl3 ready");

    push(3'd1, 32'hAAAA_5555);
    rd(5'h01, 16'h0006, "R2 ch1 over ch3");
    rd(5'h01, 16'h0006, "R4 vector reread");
    wr(5'h01, 8'h00);
    rd(5'h09, 16'h0006, "R4 ctl1 kept");
    rd(5'h19, 16'h5555, "R9 lower half");
    rd(5'h01, 16'h000A, "R10 ch3 follows");
    rd(5'h09, 16'h0002, "R5 read cleared");

    push(3'd3, 32'h0BAD_F00D);
    rd(5'h01, 16'h0002, "R2 overflow top");
    rd(5'h0B, 16'h000E, "R6 ovf set");
    rd(5'h1B, 16'hF00D, "R6 result read");
    rd(5'h0B, 16'h000A, "R6 ovf stays");

    wr(5'h00, 8'h02);
    rd(5'h01, 16'h0000, "R3 ovf disabled");
    chk_irq(1'b0, "R10 irq low");
    wr(5'h0B, 8'h02);
    rd(5'h0B, 16'h0002, "R6 sw clear");
    wr(5'h00, 8'h03);
    wr(5'h08, 8'h00);
    push(3'd0, 32'h0000_00C0);
    rd(5'h01, 16'h0000, "R3 ch0 disabled");
    rd(5'h08, 16'h0004, "R3 ch0 flag set");
    push(3'd2, 32'h0000_00C2);
    rd(5'h01, 16'h0008, "R2 vector ch2");
    chk_irq(1'b1, "R10 irq ch2");
    rd(5'h1A, 16'h00C2, "R9 ch2 low");
    wr(5'h08, 8'h00);
    rd(5'h08, 16'h0000, "R5 sw clear");

    wr(5'h0C, 8'h22);
    push(3'd4, 32'hCAFE_BEEF);
    rd(5'h01, 16'h000C, "R2 vector ch4");
    rd(5'h1C, 16'hBEEF, "R9 toggle 1st");
    rd(5'h1C, 16'hCAFE, "R9 toggle 2nd");
    rd(5'h1C, 16'hBEEF, "R9 toggle 3rd");
    rd(5'h0C, 16'h0032, "R9 ctl4 after");
    wr(5'h0D, 8'h12);
    push(3'd5, 32'h1111_2222);
    rd(5'h1D, 16'h1111, "R9 upper fixed");
    rd(5'h1D, 16'h1111, "R9 no toggle");
    rd(5'h0D, 16'h0012, "R9 ctl5");

    // delay behaviour on ch6
    push(3'd6, 32'h0000_0601);
    rd(5'h01, 16'h0010, "R2 vector ch6");
    wr(5'h16, 8'h01);
    push(3'd6, 32'h0000_0602);
    rd(5'h0E, 16'h0006, "R7 dly01 s1");
    push(3'd6, 32'h0000_0603);
    rd(5'h0E, 16'h0006, "R7 dly01 s2");
    push(3'd6, 32'h0000_0604);
    rd(5'h0E, 16'h000E, "R7 dly01 s3 ovf");
    wr(5'h0E, 8'h02);
    wr(5'h16, 8'h00);
    push(3'd6, 32'h0000_0611);
    push(3'd6, 32'h0000_0612);
    push(3'd6, 32'h0000_0613);
    rd(5'h0E, 16'h0002, "R7 dly00 s3");
    push(3'd6, 32'h0000_0614);
    rd(5'h0E, 16'h0006, "R7 dly00 s4");
    rd(5'h1E, 16'h0614, "R7 dly00 data");
    wr(5'h16, 8'hAA);
    rd(5'h16, 16'h00AA, "R8 inp readback");
    push(3'd6, 32'h0000_0621);
    rd(5'h0E, 16'h0002, "R7 dly10 s1");
    push(3'd6, 32'h0000_0622);
    rd(5'h0E, 16'h0006, "R7 dly10 s2");
    rd(5'h1E, 16'h0622, "R7 dly10 data");
    wr(5'h0E, 8'h03);
    rd(5'h0E, 16'h0002, "R8 start reads 0");
    push(3'd6, 32'h0000_0631);
    rd(5'h0E, 16'h0002, "R8 restart s1");
    push(3'd6, 32'h0000_0632);
    rd(5'h0E, 16'h0006, "R8 restart s2");
    rd(5'h1E, 16'h0632, "R8 data");
    wr(5'h16, 8'h03);
    push(3'd6, 32'h0000_0641);
    rd(5'h0E, 16'h0006, "R7 dly11 s1");

    // same-cycle read and new result
    push(3'd1, 32'h0000_1357);
    rd_push(3'd1, 16'h1357, 32'h0000_2468, "R11 old value");
    rd(5'h09, 16'h0006, "R11 flag kept");
    rd(5'h19, 16'h2468, "R11 new value");
    rd(5'h09, 16'h0002, "R11 cleared");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule